// File: doc/BRIEF.md
# Sample Event Filter Register

This block holds a 64-bit control word that says which profiling events a sample must carry before its record is kept, and it decides for each incoming sample whether the record survives. Software loads the control word through a plain write port and reads it back at all times on a read port. Each bit of the word belongs to one event number. A set bit makes that event mandatory. A clear bit makes the block disregard that event. A sample is kept only when every mandatory event is present in its 64-bit event vector, so the test is an AND over all set bits.

The feature parameters decide which bit positions exist. A position that does not exist reads as zero and is never changed by a write. A global filter-enable input bypasses the whole test, so every sample is kept while it is low. The keep decision is available combinationally. It is also registered once, together with the sample's valid flag.

The registered output stage is a two-state machine. The states are PIPE_EMPTY (no sample was presented in the previous cycle) and PIPE_LOADED (a sample was presented in the previous cycle and its decision is being shown). There are four transitions: EMPTY→LOADED and LOADED→LOADED when `smp_valid` is 1, and LOADED→EMPTY and EMPTY→EMPTY when `smp_valid` is 0.

Top module: `sample_event_filter`

## Requirements
- R1: After reset the control word reads as all zeros, `out_valid` is 0 and `out_keep` is 0.
- R2: A write with `reg_wr_en`=1 updates the control word at the next rising clock edge. The new word equals the write data ANDed with the mask of positions that exist.
- R3: The reserved positions always read as 0, whatever is written: bits 47:32, 23:19, 10:8, 4, 2 and 0.
- R4: The positions that always exist are bits 63:48, 31:24, 15:12, 7 (mispredicted), 5 (TLB walk) and 3 (level 1 data cache refill).
- R5: Each optional position exists only under its parameters: bit 18 (empty predicate) and bit 17 (partial predicate) need both `HAS_VECTOR` and `HAS_PROF_V11`; bit 16 (transactional) needs `HAS_TXMEM`; bit 11 (alignment) needs `HAS_PROF_V11`; bit 6 (not taken) needs `HAS_PROF_V12`; bit 1 (retired) needs `HAS_SPEC_SAMPLES`. With the defaults, all of these exist except bit 16.
- R6: While `filt_en`=1, `keep_comb` is 1 exactly when every bit set in the control word is also set in `smp_events`.
- R7: While `filt_en`=0, `keep_comb` is 1 for any event vector and any control word.
- R8: A control word of zero keeps every sample.
- R9: `out_valid` equals `smp_valid` from the previous cycle. `out_keep` equals the previous cycle's `keep_comb` when that cycle had `smp_valid`=1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 64 | Write data |
| reg_rd_data | output | 64 | Current control word |
| filt_en | input | 1 | Global filter enable; 0 keeps every sample |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_events | input | 64 | Event vector of the presented sample |
| keep_comb | output | 1 | Combinational keep decision |
| out_valid | output | 1 | Registered sample valid |
| out_keep | output | 1 | Registered keep decision |

## Verification
The hardest case to reach from the ports is a sample that carries every mandatory event except one that sits in a rarely set high position, such as bit 63. That sample must be dropped, and a random vector almost never lands on it. The stimulus reaches it in a directed way. It writes a word that spans the low, middle and high event groups. It then presents that exact word as the event vector, and repeats it with one bit cleared at a time. The random phase also derives each event vector from the current control word and flips a single bit of it. This places the vectors right at the boundary between kept and dropped.

// File: rtl/sef_pkg.sv
package sef_pkg;
    localparam int EVW = 64;

    typedef enum logic {
        PIPE_EMPTY,
        PIPE_LOADED
    } pipe_state_t;

    function automatic logic [EVW-1:0] writable_mask(
        input bit vec, input bit v11, input bit v12, input bit txm, input bit spec);
        logic [EVW-1:0] m;
        m = '0;
        m[63:48] = '1;
        m[31:24] = '1;
        m[15:12] = '1;
        m[7]  = 1'b1;
        m[5]  = 1'b1;
        m[3]  = 1'b1;
        m[18] = vec && v11;
        m[17] = vec && v11;
        m[16] = txm;
        m[11] = v11;
        m[6]  = v12;
        m[1]  = spec;
        return m;
    endfunction
endpackage

// File: rtl/sef_mask_reg.sv
module sef_mask_reg #(
    parameter int WIDTH = 64,
    parameter logic [WIDTH-1:0] MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wr_data & MASK;
    end

    // R2: a write lands masked on the next edge
    a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == ($past(wr_data) & MASK)));
    // R2: without a write the word holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
    // R3: absent positions stay zero
    a_r3_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK) == '0);
endmodule

// File: rtl/sef_gate.sv
module sef_gate #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] filt_vec,
    input  logic [WIDTH-1:0] events,
    input  logic             enable,
    output logic             keep
);
    logic [WIDTH-1:0] missing;

    always_comb begin
        missing = filt_vec & ~events;
        keep    = !enable || (missing == '0);
    end
endmodule

// File: rtl/sample_event_filter.sv
module sample_event_filter #(
    parameter bit HAS_VECTOR       = 1'b1,
    parameter bit HAS_PROF_V11     = 1'b1,
    parameter bit HAS_PROF_V12     = 1'b1,
    parameter bit HAS_TXMEM        = 1'b0,
    parameter bit HAS_SPEC_SAMPLES = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [63:0] reg_wr_data,
    output logic [63:0] reg_rd_data,
    input  logic        filt_en,
    input  logic        smp_valid,
    input  logic [63:0] smp_events,
    output logic        keep_comb,
    output logic        out_valid,
    output logic        out_keep
);
    import sef_pkg::*;

    localparam logic [EVW-1:0] WMASK =
        writable_mask(HAS_VECTOR, HAS_PROF_V11, HAS_PROF_V12, HAS_TXMEM, HAS_SPEC_SAMPLES);

    logic [EVW-1:0] filt_word;
    pipe_state_t    state_q, state_d;
    logic           keep_q;

    sef_mask_reg #(.WIDTH(EVW), .MASK(WMASK)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .q       (filt_word)
    );

    sef_gate #(.WIDTH(EVW)) u_gate (
        .filt_vec (filt_word),
        .events   (smp_events),
        .enable   (filt_en),
        .keep     (keep_comb)
    );

    assign reg_rd_data = filt_word;

    always_comb begin
        state_d = smp_valid ? PIPE_LOADED : PIPE_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIPE_EMPTY;
            keep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            keep_q  <= smp_valid && keep_comb;
        end
    end

    always_comb begin
        unique case (state_q)
            PIPE_EMPTY: begin
                out_valid = 1'b0;
                out_keep  = 1'b0;
            end
            PIPE_LOADED: begin
                out_valid = 1'b1;
                out_keep  = keep_q;
            end
            default: begin
                out_valid = 1'b0;
                out_keep  = 1'b0;
            end
        endcase
    end

    // R7: bypass keeps everything
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |-> keep_comb);
    // R8: empty word keeps everything
    a_r8_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data == '0) |-> keep_comb);
    // R6: an event that is mandatory but missing drops the sample
    a_r6_missing_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && ((reg_rd_data & ~smp_events) != '0)) |-> !keep_comb);
    // R9: valid is delayed one cycle
    a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> out_valid);
    a_r9_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> (!out_valid && !out_keep));
    a_r9_keep_follow: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (out_keep == $past(keep_comb)));
endmodule

// File: tb/sample_event_filter_test.sv
module sample_event_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic [63:0] reg_rd_data;
    logic        filt_en = 1'b1;
    logic        smp_valid = 1'b0;
    logic [63:0] smp_events = '0;
    logic        keep_comb, out_valid, out_keep;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sample_event_filter uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .filt_en(filt_en), .smp_valid(smp_valid),
        .smp_events(smp_events), .keep_comb(keep_comb), .out_valid(out_valid),
        .out_keep(out_keep));

    // Reference model
    logic [63:0] exp_mask;
    logic [63:0] m_word = '0;
    int          m_pipe_v[$];
    int          m_pipe_k[$];

    function automatic logic [63:0] build_mask();
        logic [63:0] m = '0;
        for (int i = 48; i < 64; i++) m[i] = 1'b1;
        for (int i = 24; i < 32; i++) m[i] = 1'b1;
        for (int i = 12; i < 16; i++) m[i] = 1'b1;
        m[7] = 1'b1; m[5] = 1'b1; m[3] = 1'b1;
        m[18] = 1'b1; m[17] = 1'b1; m[11] = 1'b1; m[6] = 1'b1; m[1] = 1'b1;
        return m;   // bit 16 absent with defaults
    endfunction

    function automatic bit ref_keep(logic [63:0] w, logic [63:0] ev, logic en);
        if (!en) return 1'b1;
        for (int i = 0; i < 64; i++)
            if (w[i] && !ev[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial exp_mask = build_mask();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word = '0;
            m_pipe_v = {};
            m_pipe_k = {};
        end else begin
            m_pipe_v.push_back(int'(smp_valid));
            m_pipe_k.push_back(int'(smp_valid && ref_keep(m_word, smp_events, filt_en)));
            if (reg_wr_en) m_word = reg_wr_data & exp_mask;
        end
    end

    // Per-cycle compare, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(reg_rd_data == m_word, "R2 word", reg_rd_data, m_word);
            check(keep_comb == ref_keep(m_word, smp_events, filt_en), "R6 keep_comb",
                  64'(keep_comb), 64'(ref_keep(m_word, smp_events, filt_en)));
            if (m_pipe_v.size() > 0) begin
                check(out_valid == m_pipe_v[$], "R9 out_valid", 64'(out_valid), 64'(m_pipe_v[$]));
                check(out_keep == m_pipe_k[$], "R9 out_keep", 64'(out_keep), 64'(m_pipe_k[$]));
                if (m_pipe_v.size() > 4) begin
                    void'(m_pipe_v.pop_front());
                    void'(m_pipe_k.pop_front());
                end
            end
        end
    end

    task automatic write_word(logic [63:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic sample(logic [63:0] ev, logic en, bit exp_keep, string req);
        smp_valid = 1'b1; smp_events = ev; filt_en = en;
        #1;
        check(keep_comb == exp_keep, req, 64'(keep_comb), 64'(exp_keep));
        @(negedge clk);
        check(out_valid && out_keep == exp_keep, "R9 registered", 64'(out_keep), 64'(exp_keep));
        smp_valid = 1'b0; filt_en = 1'b1;
    endtask

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        check(reg_rd_data == '0 && !out_valid && !out_keep, "R1 reset", reg_rd_data, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rd_data == '0, "R1 after release", reg_rd_data, 64'h0);

        write_word('1);
        check(reg_rd_data == exp_mask, "R2 all ones", reg_rd_data, exp_mask);
        check(reg_rd_data[47:32] == '0 && reg_rd_data[23:19] == '0 && reg_rd_data[10:8] == '0
              && !reg_rd_data[4] && !reg_rd_data[2] && !reg_rd_data[0], "R3 reserved", reg_rd_data, exp_mask);
        check(reg_rd_data[63:48] == '1 && reg_rd_data[31:24] == '1 && reg_rd_data[15:12] == '1
              && reg_rd_data[7] && reg_rd_data[5] && reg_rd_data[3], "R4 fixed bits", reg_rd_data, exp_mask);
        check(reg_rd_data[18] && reg_rd_data[17] && !reg_rd_data[16] && reg_rd_data[11]
              && reg_rd_data[6] && reg_rd_data[1], "R5 optional bits", reg_rd_data, exp_mask);
        write_word(~exp_mask);
        check(reg_rd_data == '0, "R3 reserved-only write", reg_rd_data, 64'h0);

        write_word('0);
        sample(64'h0, 1'b1, 1'b1, "R8 empty word, no events");
        sample(64'hDEAD_BEEF_0123_4567, 1'b1, 1'b1, "R8 empty word, events");

        write_word(64'h28);
        sample(64'h28, 1'b1, 1'b1, "R6 both present");
        sample(64'h08, 1'b1, 1'b0, "R6 walk missing");
        sample(64'h20, 1'b1, 1'b0, "R6 refill missing");
        sample(64'hFF, 1'b1, 1'b1, "R6 superset");
        sample(64'h00, 1'b0, 1'b1, "R7 bypass");

        w = 64'h8000_0000_8000_1088;
        write_word(w);
        sample(w, 1'b1, 1'b1, "R6 exact match");
        for (int b = 0; b < 64; b++)
            if (w[b]) sample(w & ~(64'h1 << b), 1'b1, 1'b0, "R6 one bit short");
        sample(64'h0, 1'b0, 1'b1, "R7 bypass with word");

        for (int n = 0; n < 400; n++) begin
            reg_wr_en   = ($urandom_range(0, 3) == 0);
            reg_wr_data = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            smp_valid   = $urandom_range(0, 1);
            filt_en     = ($urandom_range(0, 4) != 0);
            smp_events  = reg_rd_data ^ (64'h1 << $urandom_range(0, 63));
            if ($urandom_range(0, 2) == 0) smp_events = reg_rd_data | {$urandom(), $urandom()};
            @(negedge clk);
        end
        reg_wr_en = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule